// File: doc/BRIEF.md
# SPI Master with Mode-Fault Protection

This block is a full-duplex SPI controller that software configures through a small four-word register interface. It comes out of reset as a disabled slave. Software first chooses where the internal slave-select level comes from: either a software level bit or the external select pin. It then sets the master bit while the block is still disabled, and then enables it. A transfer runs when software sets a start bit with a frame already waiting in the transmit register. The block drives SCK in mode 0 (idle low, sample on the rising edge, shift on the falling edge). It sends each frame MSB first on MOSI and collects MISO into a one-frame receive register.

Protection comes from the mode-fault check. If the block is a master and the internal slave-select goes low, it clears its master bit, enable and start bits, stops the frame in progress, and raises a sticky fault flag. Enabling is refused while that flag is set. Clearing the flag returns the block to disabled slave mode, and software must set it up again.

The end-of-transfer flag counts completed frames against a programmed count. A count of zero selects open-ended streaming: frames keep going while software refills the transmit register, and the flag never rises.

Top module: `spiFaultMaster`

## Requirements
- R1: After reset every control bit, configuration field and status flag reads 0, so the block is a disabled slave, and SCK and MOSI are low.
- R2: A write to the master bit (CTRL bit 1) takes effect only while enable (CTRL bit 0) is 0. While the block is enabled, the stored master bit keeps its value.
- R3: The internal slave-select equals the software level bit (CTRL bit 3) when software management (CTRL bit 2) is 1, and equals the ssPin input otherwise.
- R4: When master is 1 and the internal slave-select is 0, the next clock edge sets the fault flag (STATUS bit 1) and clears master, enable and start. Any frame in progress is dropped, SCK returns low and busy (STATUS bit 3) reads 0.
- R5: While the fault flag is set, writing 1 to enable has no effect. Writing 1 to STATUS bit 1 clears the flag and leaves master at 0.
- R6: The frame-size field CFG[3:0] holds the number of bits per frame minus one. A value of N gives exactly N+1 SCK pulses per frame.
- R7: A frame starts only when start (CTRL bit 4) is 1, enable and master are 1, and a word has been written to DATA (address 2). A start write is ignored unless the block is already enabled in master mode. Without transmit data, SCK stays idle.
- R8: SCK is idle low. MISO is sampled on each rising edge, MOSI changes on falling edges, and bits go MSB first. Each SCK half period lasts CFG[15:8]+1 clock cycles.
- R9: With count CFG[23:16] greater than 0, the end-of-transfer flag (STATUS bit 0) rises after that many frames, and start clears itself at the same moment. With count 0, the flag never rises and start stays set.
- R10: Writing 1 to STATUS bit 0 clears the end-of-transfer flag.
- R11: The receive-valid flag (STATUS bit 2) is set when a frame completes. A read of DATA returns the received frame, right-aligned, and clears the flag.
- R12: Register addresses are CTRL 0, CFG 1, DATA 2, STATUS 3. Reads return zero in unused bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (a DATA read clears receive-valid) |
| regAddr | input | 2 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| sck | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out, MSB first |
| miso | input | 1 | Serial data in |
| ssPin | input | 1 | External slave-select level, used when software management is off |

## Verification
The bench sweeps every frame size at two divider settings and two MISO patterns. A design with the bit order reversed or an off-by-one bit count would return the wrong word or the wrong pulse count. It raises the fault both from the software level and from the pin, and once in the middle of a frame. A design that kept master set, let enable back in, or kept clocking would show SCK edges or the wrong control read-back. It also tries a master write while enabled and a start write before enable; a design that accepted either would start SCK when it should not. Multi-frame runs with count 3 and with count 0 show whether end-of-transfer fires early, late, or in streaming mode, where it must never fire.

// File: rtl/spiPkg.sv
package spiPkg;
  localparam int REG_W = 32;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  // CTRL bit positions
  localparam int CTL_EN     = 0;
  localparam int CTL_MASTER = 1;
  localparam int CTL_SWSEL  = 2;
  localparam int CTL_SWLVL  = 3;
  localparam int CTL_START  = 4;

  // CFG field offsets
  localparam int CFG_DIV_LSB = 8;
  localparam int CFG_CNT_LSB = 16;

  // STATUS bit positions
  localparam int ST_EOT   = 0;
  localparam int ST_FAULT = 1;
  localparam int ST_RXV   = 2;
  localparam int ST_BUSY  = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic abort;
  } dpCmd_t;

  // events from datapath to control
  typedef struct packed {
    logic frameDone;
    logic busy;
  } dpStat_t;
endpackage

// File: rtl/spiShift.sv
module spiShift
  import spiPkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int BITS_W   = $clog2(MAX_BITS),
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCmd_t              cmd,
  input  logic [MAX_BITS-1:0] txData,
  input  logic [BITS_W-1:0]   bitsM1,
  input  logic [DIV_W-1:0]    clkDiv,
  input  logic                miso,
  output logic                sck,
  output logic                mosi,
  output dpStat_t             stat,
  output logic [MAX_BITS-1:0] rxWord
);
  logic                busy;
  logic                frameDone;
  logic [DIV_W-1:0]    divCnt;
  logic [BITS_W-1:0]   bitIdx;
  logic [MAX_BITS-1:0] txShift;
  logic [MAX_BITS-1:0] rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      sck       <= 1'b0;
      frameDone <= 1'b0;
      divCnt    <= '0;
      bitIdx    <= '0;
      txShift   <= '0;
      rxShift   <= '0;
    end else begin
      frameDone <= 1'b0;
      if (cmd.abort) begin
        busy <= 1'b0;
        sck  <= 1'b0;
      end else if (cmd.load) begin
        busy    <= 1'b1;
        sck     <= 1'b0;
        divCnt  <= '0;
        txShift <= txData;
        bitIdx  <= bitsM1;
        rxShift <= '0;
      end else if (busy) begin
        if (divCnt == clkDiv) begin
          divCnt <= '0;
          sck    <= ~sck;
          if (!sck) begin
            // rising edge: capture incoming bit
            rxShift <= {rxShift[MAX_BITS-2:0], miso};
          end else if (bitIdx == '0) begin
            busy      <= 1'b0;
            frameDone <= 1'b1;
          end else begin
            // falling edge: advance to next outgoing bit
            bitIdx <= bitIdx - 1'b1;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign mosi           = busy ? txShift[bitIdx] : 1'b0;
  assign rxWord         = rxShift;
  assign stat.frameDone = frameDone;
  assign stat.busy      = busy;
endmodule

// File: rtl/spiCtrl.sv
module spiCtrl
  import spiPkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int BITS_W   = $clog2(MAX_BITS),
  parameter int DIV_W    = 8,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic                regRe,
  input  logic [1:0]          regAddr,
  input  logic [REG_W-1:0]    regWdata,
  output logic [REG_W-1:0]    regRdata,
  input  logic                ssPin,
  input  dpStat_t             dpStat,
  input  logic [MAX_BITS-1:0] rxWord,
  output dpCmd_t              cmd,
  output logic [MAX_BITS-1:0] txData,
  output logic [BITS_W-1:0]   bitsM1,
  output logic [DIV_W-1:0]    clkDiv,
  output logic [CNT_W-1:0]    cfgCount,
  output logic                enable,
  output logic                master,
  output logic                fault,
  output logic                eot,
  output logic                start,
  output logic                ssInt
);
  logic                swSel, swLevel;
  logic                txFull, rxValid;
  logic [MAX_BITS-1:0] rxData;
  logic [CNT_W-1:0]    frameCnt;
  logic                faultCond;
  logic                wrCtrl, wrCfg, wrData, wrStat, rdData;
  logic                startOk;
  logic                unusedWdata;

  assign unusedWdata = ^regWdata;

  assign wrCtrl = regWe && (regAddr == ADDR_CTRL);
  assign wrCfg  = regWe && (regAddr == ADDR_CFG);
  assign wrData = regWe && (regAddr == ADDR_DATA);
  assign wrStat = regWe && (regAddr == ADDR_STAT);
  assign rdData = regRe && (regAddr == ADDR_DATA);

  assign ssInt     = swSel ? swLevel : ssPin;
  assign faultCond = master & ~ssInt;
  assign startOk   = regWdata[CTL_START] & enable & master;

  assign cmd.load  = start & enable & master & ssInt & txFull & ~dpStat.busy;
  assign cmd.abort = faultCond;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable   <= 1'b0;
      master   <= 1'b0;
      swSel    <= 1'b0;
      swLevel  <= 1'b0;
      start    <= 1'b0;
      fault    <= 1'b0;
      eot      <= 1'b0;
      txFull   <= 1'b0;
      rxValid  <= 1'b0;
      txData   <= '0;
      rxData   <= '0;
      bitsM1   <= '0;
      clkDiv   <= '0;
      cfgCount <= '0;
      frameCnt <= '0;
    end else begin
      if (wrCtrl) begin
        swSel   <= regWdata[CTL_SWSEL];
        swLevel <= regWdata[CTL_SWLVL];
        enable  <= regWdata[CTL_EN] & ~fault;
        if (!enable) master <= regWdata[CTL_MASTER];
        start <= startOk;
        if (startOk && !start) frameCnt <= '0;
      end
      if (wrCfg) begin
        bitsM1   <= regWdata[BITS_W-1:0];
        clkDiv   <= regWdata[CFG_DIV_LSB +: DIV_W];
        cfgCount <= regWdata[CFG_CNT_LSB +: CNT_W];
      end
      if (cmd.load) txFull <= 1'b0;
      if (wrData) begin
        txData <= regWdata[MAX_BITS-1:0];
        txFull <= 1'b1;
      end
      if (rdData) rxValid <= 1'b0;
      if (wrStat && regWdata[ST_EOT])   eot   <= 1'b0;
      if (wrStat && regWdata[ST_FAULT]) fault <= 1'b0;
      if (dpStat.frameDone) begin
        rxData  <= rxWord;
        rxValid <= 1'b1;
        if (cfgCount != '0 && CNT_W'(frameCnt + 1'b1) == cfgCount) begin
          eot      <= 1'b1;
          start    <= 1'b0;
          frameCnt <= '0;
        end else begin
          frameCnt <= frameCnt + 1'b1;
        end
      end
      if (faultCond) begin
        fault  <= 1'b1;
        master <= 1'b0;
        enable <= 1'b0;
        start  <= 1'b0;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdata[CTL_EN]     = enable;
        regRdata[CTL_MASTER] = master;
        regRdata[CTL_SWSEL]  = swSel;
        regRdata[CTL_SWLVL]  = swLevel;
        regRdata[CTL_START]  = start;
      end
      ADDR_CFG: begin
        regRdata[BITS_W-1:0]             = bitsM1;
        regRdata[CFG_DIV_LSB +: DIV_W]   = clkDiv;
        regRdata[CFG_CNT_LSB +: CNT_W]   = cfgCount;
      end
      ADDR_DATA: regRdata[MAX_BITS-1:0] = rxData;
      default: begin
        regRdata[ST_EOT]   = eot;
        regRdata[ST_FAULT] = fault;
        regRdata[ST_RXV]   = rxValid;
        regRdata[ST_BUSY]  = dpStat.busy;
      end
    endcase
  end
endmodule

// File: rtl/spiFaultMaster.sv
module spiFaultMaster
  import spiPkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int DIV_W    = 8,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic             regRe,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  input  logic             ssPin
);
  localparam int BITS_W = $clog2(MAX_BITS);

  dpCmd_t              dpCmd;
  dpStat_t             dpStat;
  logic [MAX_BITS-1:0] txData, rxWord;
  logic [BITS_W-1:0]   bitsM1;
  logic [DIV_W-1:0]    clkDiv;
  logic [CNT_W-1:0]    cfgCount;
  logic                enable, master, fault, eot, start, ssInt;
  logic                dpBusy;

  assign dpBusy = dpStat.busy;

  spiCtrl #(
    .MAX_BITS(MAX_BITS), .BITS_W(BITS_W), .DIV_W(DIV_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .ssPin(ssPin), .dpStat(dpStat), .rxWord(rxWord),
    .cmd(dpCmd), .txData(txData), .bitsM1(bitsM1), .clkDiv(clkDiv),
    .cfgCount(cfgCount), .enable(enable), .master(master), .fault(fault),
    .eot(eot), .start(start), .ssInt(ssInt)
  );

  spiShift #(
    .MAX_BITS(MAX_BITS), .BITS_W(BITS_W), .DIV_W(DIV_W)
  ) u_shift (
    .clk(clk), .rstN(rstN), .cmd(dpCmd), .txData(txData),
    .bitsM1(bitsM1), .clkDiv(clkDiv), .miso(miso),
    .sck(sck), .mosi(mosi), .stat(dpStat), .rxWord(rxWord)
  );
endmodule

// File: rtl/spiChecker.sv
module spiChecker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             sck,
  input logic             busy,
  input logic             enable,
  input logic             master,
  input logic             fault,
  input logic             eot,
  input logic             start,
  input logic             ssInt,
  input logic [CNT_W-1:0] cfgCount
);
  a_r4_fault_drops_master: assert property (@(posedge clk) disable iff (!rstN)
    (master && !ssInt) |=> (fault && !master && !enable && !start));

  a_r5_no_enable_while_fault: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> !enable);

  a_r2_master_set_only_disabled: assert property (@(posedge clk) disable iff (!rstN)
    $rose(master) |-> !$past(enable));

  a_r8_sck_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sck);

  a_r9_eot_needs_count: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eot) |-> (cfgCount != '0 && !start));

  a_r7_frame_needs_enabled_master: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(master && enable));
endmodule

bind spiFaultMaster spiChecker #(.CNT_W(CNT_W)) u_spiChecker (
  .clk(clk), .rstN(rstN), .sck(sck), .busy(dpBusy), .enable(enable),
  .master(master), .fault(fault), .eot(eot), .start(start),
  .ssInt(ssInt), .cfgCount(cfgCount)
);

// File: tb/test_spiFaultMaster.sv
module test_spiFaultMaster;
  localparam logic [1:0] A_CTRL = 2'd0, A_CFG = 2'd1, A_DATA = 2'd2, A_STAT = 2'd3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        sck, mosi, miso;
  logic        ssPin = 1'b1;

  always #4 clk = ~clk;

  spiFaultMaster i_spiFaultMaster (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sck(sck), .mosi(mosi),
    .miso(miso), .ssPin(ssPin)
  );

  int nRun = 0, nFail = 0;

  // slave model: counts SCK rising edges, collects MOSI, serves a pattern MSB first
  logic        monClr = 1'b0;
  int          riseCnt = 0;
  logic [15:0] slvIn = '0;
  logic [15:0] slvPat = '0;
  int          curM1 = 7;
  int          hiCnt = 0, lastHi = 0;

  always @(posedge sck or posedge monClr) begin
    if (monClr) begin
      riseCnt <= 0;
      slvIn   <= '0;
    end else begin
      riseCnt <= riseCnt + 1;
      slvIn   <= {slvIn[14:0], mosi};
    end
  end

  always_comb miso = slvPat[curM1 - (riseCnt % (curM1 + 1))];

  always @(posedge clk) begin
    if (sck) hiCnt <= hiCnt + 1;
    else if (hiCnt != 0) begin
      lastHi <= hiCnt;
      hiCnt  <= 0;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regRe = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic clrMon();
    monClr = 1'b1;
    #1 monClr = 1'b0;
  endtask

  task automatic pollBit(int b);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(A_STAT, v);
      if (v[b]) return;
    end
    nRun++; nFail++;
    $display("FAIL R9: timeout on status bit %0d actual 0 expected 1", b);
  endtask

  task automatic runFrame(int m1, int dv, logic [15:0] tx, logic [15:0] pat);
    logic [31:0] v, mask;
    mask = (32'd1 << (m1 + 1)) - 1;
    wr(A_CFG, (32'd1 << 16) | (32'(dv) << 8) | 32'(m1));
    curM1 = m1; slvPat = pat;
    clrMon();
    wr(A_DATA, {16'd0, tx});
    wr(A_CTRL, 32'h1F);
    pollBit(0);
    check("R8 mosi msb first", {16'd0, slvIn} & mask, {16'd0, tx} & mask);
    check("R6 pulse count", riseCnt, m1 + 1);
    check("R8 half period", lastHi, dv + 1);
    rd(A_STAT, v); check("R9 R11 status after frame", v, 32'h5);
    rd(A_DATA, v); check("R8 R11 rx word", v, {16'd0, pat} & mask);
    rd(A_STAT, v); check("R11 rx valid cleared", v, 32'h1);
    rd(A_CTRL, v); check("R9 start self-clear", v, 32'h0F);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); check("R10 eot clear", v, 32'h0);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    nRun++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    int r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 sck low", {31'd0, sck}, 32'd0);
    check("R1 mosi low", {31'd0, mosi}, 32'd0);
    rd(A_CTRL, v); check("R1 R12 ctrl", v, 32'h0);
    rd(A_CFG, v);  check("R1 R12 cfg", v, 32'h0);
    rd(A_STAT, v); check("R1 R12 status", v, 32'h0);

    // R4 fault from software level
    wr(A_CTRL, 32'h04);
    wr(A_CTRL, 32'h06);
    rd(A_STAT, v); check("R4 fault flag sw", v, 32'h2);
    rd(A_CTRL, v); check("R4 master dropped", v, 32'h04);
    // R5 enable refused while faulted
    wr(A_CTRL, 32'h05);
    rd(A_CTRL, v); check("R5 enable refused", v, 32'h04);
    wr(A_STAT, 32'h2);
    rd(A_STAT, v); check("R5 fault cleared", v, 32'h0);
    rd(A_CTRL, v); check("R5 stays slave", v, 32'h04);

    // R3 pin source
    ssPin = 1'b0;
    wr(A_CTRL, 32'h00);
    wr(A_CTRL, 32'h02);
    rd(A_STAT, v); check("R3 pin low faults", v, 32'h2);
    wr(A_STAT, 32'h2);
    ssPin = 1'b1;
    wr(A_CTRL, 32'h02);
    rd(A_STAT, v); check("R3 pin high no fault", v, 32'h0);
    rd(A_CTRL, v); check("R3 master held", v, 32'h02);
    ssPin = 1'b0;
    repeat (2) @(negedge clk);
    rd(A_STAT, v); check("R3 pin drop faults", v, 32'h2);
    rd(A_CTRL, v); check("R3 R4 master cleared", v, 32'h00);
    wr(A_STAT, 32'h2);
    // software select overrides low pin
    wr(A_CTRL, 32'h0C);
    wr(A_CTRL, 32'h0E);
    rd(A_STAT, v); check("R3 sw level overrides pin", v, 32'h0);
    rd(A_CTRL, v); check("R3 master via sw", v, 32'h0E);
    ssPin = 1'b1;

    // R2 master write ignored while enabled
    wr(A_CTRL, 32'h0C);
    wr(A_CTRL, 32'h0D);
    wr(A_CTRL, 32'h0F);
    rd(A_CTRL, v); check("R2 master locked while enabled", v, 32'h0D);
    wr(A_CTRL, 32'h0C);
    wr(A_CTRL, 32'h0E);
    wr(A_CTRL, 32'h0F);
    rd(A_CTRL, v); check("R2 master set while disabled", v, 32'h0F);

    // R7 start without transmit data
    clrMon();
    wr(A_CTRL, 32'h1F);
    repeat (60) @(negedge clk);
    check("R7 no sck without data", riseCnt, 0);
    rd(A_CTRL, v); check("R7 start held", v, 32'h1F);
    rd(A_STAT, v); check("R7 idle status", v, 32'h0);
    wr(A_CTRL, 32'h0F);

    // R7 start before enable is ignored
    wr(A_CTRL, 32'h0E);
    wr(A_DATA, 32'hA5);
    wr(A_CTRL, 32'h1E);
    rd(A_CTRL, v); check("R7 start refused when disabled", v, 32'h0E);
    wr(A_CTRL, 32'h0F);
    repeat (60) @(negedge clk);
    check("R7 no sck before start", riseCnt, 0);
    wr(A_CFG, (32'd1 << 16) | 32'd7);
    curM1 = 7; slvPat = 16'h3C;
    wr(A_CTRL, 32'h1F);
    pollBit(0);
    check("R7 pending word sent", {16'd0, slvIn} & 32'hFF, 32'hA5);
    rd(A_DATA, v); check("R7 pending word rx", v, 32'h3C);
    wr(A_STAT, 32'h1);

    // R6 R8 sweep of frame sizes
    for (int m = 0; m < 16; m++) begin
      for (int d = 0; d < 2; d++) begin
        runFrame(m, d * 2, 16'hB4E1 ^ 16'(m * 16'h1111), 16'h5A3C);
        runFrame(m, d * 2, 16'h0F69 + 16'(m), 16'hC3A5 ^ 16'(m));
      end
    end

    // R9 multi-frame count 3
    wr(A_CFG, (32'd3 << 16) | (32'd1 << 8) | 32'd7);
    curM1 = 7; slvPat = 16'h96;
    clrMon();
    wr(A_DATA, 32'h11);
    wr(A_CTRL, 32'h1F);
    for (int k = 0; k < 3; k++) begin
      pollBit(2);
      rd(A_STAT, v); check("R9 eot only on last frame", v, (k == 2) ? 32'h5 : 32'h4);
      rd(A_DATA, v); check("R11 multi rx", v, 32'h96);
      if (k < 2) wr(A_DATA, 32'h22 * (k + 2));
    end
    check("R9 last tx", {16'd0, slvIn} & 32'hFF, 32'h66);
    check("R9 total pulses", riseCnt, 24);
    rd(A_CTRL, v); check("R9 start cleared after count", v, 32'h0F);
    wr(A_STAT, 32'h1);

    // R9 count zero: streaming, no eot
    wr(A_CFG, 32'd4);
    curM1 = 4; slvPat = 16'h15;
    clrMon();
    wr(A_DATA, 32'h0A);
    wr(A_CTRL, 32'h1F);
    for (int k = 0; k < 2; k++) begin
      pollBit(2);
      rd(A_STAT, v); check("R9 count zero no eot", v, 32'h4);
      rd(A_DATA, v); check("R11 stream rx", v, 32'h15);
      if (k == 0) wr(A_DATA, 32'h13);
    end
    rd(A_CTRL, v); check("R9 start stays with count zero", v, 32'h1F);
    wr(A_CTRL, 32'h0F);

    // R4 fault in the middle of a frame
    wr(A_CFG, (32'd1 << 16) | (32'd7 << 8) | 32'd15);
    curM1 = 15; slvPat = 16'hFFFF;
    clrMon();
    wr(A_DATA, 32'h1234);
    wr(A_CTRL, 32'h1F);
    repeat (40) @(negedge clk);
    wr(A_CTRL, 32'h07);
    repeat (2) @(negedge clk);
    check("R4 sck low on abort", {31'd0, sck}, 32'd0);
    rd(A_STAT, v); check("R4 fault mid-frame", v, 32'h2);
    rd(A_CTRL, v); check("R4 ctrl after abort", v, 32'h04);
    r = riseCnt;
    repeat (100) @(negedge clk);
    check("R4 no further sck", riseCnt, r);
    wr(A_STAT, 32'h2);
    rd(A_STAT, v); check("R5 fault clear after abort", v, 32'h0);

    finishRun();
  end
endmodule